// File: doc/BRIEF.md
# Sparse Hit-Run Encoder for One Column Bank

This block takes one 64-column slice of a binary detector row, in which a column set to 1 is a hit, and reduces it to a short list of hit pieces. Each piece names the column where it starts and how many adjacent hit columns it covers, from one to four. A run of adjacent hits longer than four is split into consecutive pieces of four, counted from the first hit of the run. The last piece of a run may be shorter. The pieces are found by a priority look-ahead search, so the lowest column is reported first.

A full row is covered by a chain of identical banks. Each bank passes a 2-bit carry to the bank above it. The carry says how many hits of a still-open piece end at the bank's top column. The next bank uses it to cut its first piece short, so that the four-column grouping of a run continues across the bank edge. No hit is lost and none is counted twice. The carry output depends only on the slice and the carry input within the same cycle, so the whole row chain settles in one clock.

Slices arrive on a valid/ready input. Results come out one cycle later on a registered valid/ready output. A new slice is taken only when the output register is empty or is being emptied in that same cycle. While the output is held, the output fields stay unchanged and the input is not accepted. At most SLOTS pieces are reported per slice. Any further pieces are dropped and flagged.

Top module: `sparse_bank_encoder`

## Requirements
- R1: A column whose input bit is 1 is a hit. Each reported piece gives its start column as a 6-bit index and its size as a 2-bit code equal to size minus one, so 00 means one hit and 11 means four hits. A run longer than four is split into pieces of four from its first hit, and the remainder forms the last piece.
- R2: Valid pieces fill slots 0 upward, in ascending start-column order. Unused slots have their valid bit at 0.
- R3: At most SLOTS pieces (default 6) are reported. When a slice holds more pieces than that, the lowest SLOTS pieces are kept, the rest are dropped, and `res_overflow` is 1 for that result. Otherwise `res_overflow` is 0.
- R4: `in_carry` (0 to 3) gives the number of hits in an open piece that ends at the top column of the lower neighbour. When column 0 is a hit and the carry is k > 0, the first piece is limited to 4 − k hits. When column 0 is not a hit, the carry has no effect.
- R5: `out_carry` gives the number of hits in the piece still open at column 63, taking `in_carry` into account. It is 0 when column 63 is not a hit or when that piece holds exactly four hits. It is combinational from `in_hits` and `in_carry`.
- R6: A slice accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on the result outputs, with `res_valid` set to 1, just after the next edge.
- R7: `in_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. While `res_valid` is 1 and `res_ready` is 0, every result output holds its value.
- R8: During reset, `res_valid`, all slot valid bits and `res_overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Slice present |
| in_ready | output | 1 | Slice will be taken on this edge |
| in_hits | input | 64 | Binary column outputs of the slice, bit i is column i |
| in_carry | input | 2 | Hits of the open piece from the lower bank |
| out_carry | output | 2 | Hits of the open piece at column 63, for the upper bank |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result on this edge |
| slot_valid | output | 6 | Valid bit per slot |
| slot_col | output | 36 | Start column per slot, slot k at bits 6k+5:6k |
| slot_len | output | 12 | Size code per slot, slot k at bits 2k+1:2k |
| res_overflow | output | 1 | More pieces existed than slots |

## Verification
The bench covers the following slice patterns:
- Empty slices and single isolated hits check address encoding at column 0, in the middle and at column 63.
- Runs of exactly four, longer runs, and a completely full slice separate correct splitting into fours from off-by-one grouping.
- Runs that touch column 63 give each possible carry-out value, including the full-piece case that must return 0.
- Slices with exactly six pieces and with seven pieces distinguish a full result from an overflow.
- Nonzero carry inputs are applied both with column 0 hit and with column 0 idle, which shows that the first piece is shortened only when the run actually continues.
- A held output with a pending second slice checks that back-pressure holds the result and delays acceptance.

// File: rtl/bank_enc_pkg.sv
package bank_enc_pkg;
  // Longest run of adjacent hits one reported piece may cover.
  localparam int RUN_CAP = 4;
  // Width of the size code and of the inter-bank carry.
  localparam int LEN_W = 2;

  typedef logic [LEN_W-1:0] len_code_t;
  typedef logic [LEN_W-1:0] phase_t;
  typedef logic [LEN_W:0]   count_t;
endpackage

// File: rtl/bank_run_marker.sv
module bank_run_marker
  import bank_enc_pkg::*;
#(
  parameter int COLS = 64
) (
  input  logic [COLS-1:0]            hits,
  input  phase_t                     carry_in,
  output logic [COLS-1:0]            start_mask,
  output logic [COLS-1:0][LEN_W-1:0] len_code,
  output phase_t                     carry_out
);
  // Phase = hits already in the open piece when a column is reached.
  phase_t phase [COLS+1];
  logic [COLS+RUN_CAP-1:0] hits_pad;

  assign hits_pad  = {{RUN_CAP{1'b0}}, hits};
  assign phase[0]  = carry_in;
  assign carry_out = phase[COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    count_t nxt;
    count_t cap;
    count_t run;
    count_t size;

    assign nxt = {1'b0, phase[c]} + count_t'(1);
    assign phase[c+1] = (hits[c] && (nxt != count_t'(RUN_CAP))) ? nxt[LEN_W-1:0] : '0;

    // Column 0 opens a piece in this bank even when the run is continuing.
    if (c == 0) begin : g_first
      assign start_mask[c] = hits[c];
      assign cap = (phase[0] != '0) ? count_t'(RUN_CAP) - {1'b0, phase[0]}
                                    : count_t'(RUN_CAP);
    end else begin : g_rest
      assign start_mask[c] = hits[c] && (phase[c] == '0);
      assign cap = count_t'(RUN_CAP);
    end

    // Look ahead over the next RUN_CAP-1 columns for the run extent.
    always_comb begin
      logic chain;
      chain = 1'b1;
      run   = count_t'(1);
      for (int j = 1; j < RUN_CAP; j++) begin
        chain = chain & hits_pad[c+j];
        run   = run + count_t'(chain);
      end
    end

    assign size        = (run < cap) ? run : cap;
    assign len_code[c] = len_code_t'(size - count_t'(1));
  end
endmodule

// File: rtl/bank_slot_picker.sv
module bank_slot_picker
  import bank_enc_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int SLOTS = 6,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic [COLS-1:0]            start_mask,
  input  logic [COLS-1:0][LEN_W-1:0] len_code,
  output logic [SLOTS-1:0]           pick_valid,
  output logic [SLOTS-1:0][COL_W-1:0] pick_col,
  output logic [SLOTS-1:0][LEN_W-1:0] pick_len,
  output logic                       pick_overflow
);
  logic [COLS-1:0] remain [SLOTS+1];

  assign remain[0] = start_mask;
  assign pick_overflow = |remain[SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [COLS-1:0] lowest;

    // Isolate the lowest pending start; higher slots see it removed.
    assign lowest        = remain[k] & (~remain[k] + COLS'(1));
    assign remain[k+1]   = remain[k] & ~lowest;
    assign pick_valid[k] = |remain[k];

    always_comb begin
      pick_col[k] = '0;
      pick_len[k] = '0;
      for (int i = 0; i < COLS; i++) begin
        if (lowest[i]) begin
          pick_col[k] = pick_col[k] | COL_W'(i);
          pick_len[k] = pick_len[k] | len_code[i];
        end
      end
    end
  end
endmodule

// File: rtl/bank_out_stage.sv
module bank_out_stage
  import bank_enc_pkg::*;
#(
  parameter int SLOTS = 6,
  parameter int COL_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        drain,
  input  logic [SLOTS-1:0]            d_valid,
  input  logic [SLOTS-1:0][COL_W-1:0] d_col,
  input  logic [SLOTS-1:0][LEN_W-1:0] d_len,
  input  logic                        d_overflow,
  output logic                        q_full,
  output logic [SLOTS-1:0]            q_valid,
  output logic [SLOTS-1:0][COL_W-1:0] q_col,
  output logic [SLOTS-1:0][LEN_W-1:0] q_len,
  output logic                        q_overflow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_full     <= 1'b0;
      q_valid    <= '0;
      q_col      <= '0;
      q_len      <= '0;
      q_overflow <= 1'b0;
    end else if (load) begin
      q_full     <= 1'b1;
      q_valid    <= d_valid;
      q_col      <= d_col;
      q_len      <= d_len;
      q_overflow <= d_overflow;
    end else if (drain) begin
      q_full     <= 1'b0;
    end
  end
endmodule

// File: rtl/sparse_bank_encoder.sv
module sparse_bank_encoder
  import bank_enc_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int SLOTS = 6,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [COLS-1:0]          in_hits,
  input  logic [LEN_W-1:0]         in_carry,
  output logic [LEN_W-1:0]         out_carry,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [SLOTS*COL_W-1:0]   slot_col,
  output logic [SLOTS*LEN_W-1:0]   slot_len,
  output logic                     res_overflow
);
  logic [COLS-1:0]             start_mask;
  logic [COLS-1:0][LEN_W-1:0]  len_code;
  logic [SLOTS-1:0]            pick_valid;
  logic [SLOTS-1:0][COL_W-1:0] pick_col;
  logic [SLOTS-1:0][LEN_W-1:0] pick_len;
  logic                        pick_overflow;
  logic [SLOTS-1:0][COL_W-1:0] q_col;
  logic [SLOTS-1:0][LEN_W-1:0] q_len;
  logic                        accept;

  assign in_ready = !res_valid || res_ready;
  assign accept   = in_valid && in_ready;

  bank_run_marker #(.COLS(COLS)) marker_i (
    .hits       (in_hits),
    .carry_in   (in_carry),
    .start_mask (start_mask),
    .len_code   (len_code),
    .carry_out  (out_carry)
  );

  bank_slot_picker #(.COLS(COLS), .SLOTS(SLOTS), .COL_W(COL_W)) picker_i (
    .start_mask    (start_mask),
    .len_code      (len_code),
    .pick_valid    (pick_valid),
    .pick_col      (pick_col),
    .pick_len      (pick_len),
    .pick_overflow (pick_overflow)
  );

  bank_out_stage #(.SLOTS(SLOTS), .COL_W(COL_W)) stage_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .drain      (res_ready),
    .d_valid    (pick_valid),
    .d_col      (pick_col),
    .d_len      (pick_len),
    .d_overflow (pick_overflow),
    .q_full     (res_valid),
    .q_valid    (slot_valid),
    .q_col      (q_col),
    .q_len      (q_len),
    .q_overflow (res_overflow)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_flat
    assign slot_col[k*COL_W +: COL_W] = q_col[k];
    assign slot_len[k*LEN_W +: LEN_W] = q_len[k];
  end
endmodule

// File: rtl/bank_enc_checker.sv
module bank_enc_checker #(
  parameter int COLS  = 64,
  parameter int SLOTS = 6,
  parameter int COL_W = 6,
  parameter int LEN_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [COLS-1:0]        in_hits,
  input logic [LEN_W-1:0]       out_carry,
  input logic                   res_valid,
  input logic                   res_ready,
  input logic [SLOTS-1:0]       slot_valid,
  input logic [SLOTS*COL_W-1:0] slot_col,
  input logic [SLOTS*LEN_W-1:0] slot_len,
  input logic                   res_overflow
);
  // R2
  contiguous_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((slot_valid & (slot_valid + SLOTS'(1))) == '0));

  for (genvar k = 0; k + 1 < SLOTS; k++) begin : g_order
    // R2
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && slot_valid[k+1]) |->
        (slot_col[(k+1)*COL_W +: COL_W] > slot_col[k*COL_W +: COL_W]));
  end

  // R3
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_overflow) |-> (&slot_valid));

  // R5
  carry_needs_top_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_carry != '0) |-> in_hits[COLS-1]);

  // R6
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  // R7
  hold_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(slot_valid) && $stable(slot_col) &&
       $stable(slot_len) && $stable(res_overflow)));

  // R8
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!res_valid && (slot_valid == '0) && !res_overflow));
endmodule

bind sparse_bank_encoder bank_enc_checker #(
  .COLS(COLS), .SLOTS(SLOTS), .COL_W(COL_W), .LEN_W(bank_enc_pkg::LEN_W)
) chk_i (.*);

// File: tb/sparse_bank_encoder_tb_top.sv
`timescale 1ns/1ps
module sparse_bank_encoder_tb_top;
  localparam int COLS = 64;
  localparam int SLOTS = 6;
  localparam int COL_W = 6;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [COLS-1:0] in_hits = '0;
  logic [1:0] in_carry = '0;
  logic [1:0] out_carry;
  logic res_valid;
  logic res_ready = 1'b1;
  logic [SLOTS-1:0] slot_valid;
  logic [SLOTS*COL_W-1:0] slot_col;
  logic [SLOTS*2-1:0] slot_len;
  logic res_overflow;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sparse_bank_encoder #(.COLS(COLS), .SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hits(in_hits), .in_carry(in_carry), .out_carry(out_carry),
    .res_valid(res_valid), .res_ready(res_ready), .slot_valid(slot_valid),
    .slot_col(slot_col), .slot_len(slot_len), .res_overflow(res_overflow)
  );

  // Stimulus and expected summary: hits, carry-in, piece count, overflow,
  // carry-out, first piece column and size code.
  localparam logic [63:0] T_HITS [NV] = '{
    64'h0, 64'h1, 64'hF0, 64'h3F00, 64'h8000_0000_0000_0000,
    64'hE000_0000_0000_0000, 64'hF000_0000_0000_0000, 64'h7, 64'h1, 64'h0,
    64'h5555_5555_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h555, 64'h1555};
  localparam logic [1:0] T_CIN  [NV] = '{0,0,0,0,0, 0,0,2,3,3, 0,0,1,0,0};
  localparam int         T_CNT  [NV] = '{0,1,1,2,1, 1,1,2,1,0, 6,6,6,6,6};
  localparam logic       T_OVF  [NV] = '{0,0,0,0,0, 0,0,0,0,0, 1,1,1,0,1};
  localparam logic [1:0] T_COUT [NV] = '{0,0,0,0,1, 3,0,0,0,0, 0,0,1,0,0};
  localparam int         T_COL0 [NV] = '{0,0,4,8,63, 61,60,0,0,0, 0,0,0,0,0};
  localparam logic [1:0] T_LEN0 [NV] = '{0,0,3,3,0, 2,3,1,0,0, 0,3,2,0,0};

  int m_cnt;
  logic m_ovf;
  logic [1:0] m_cout;
  int m_col [SLOTS];
  int m_len [SLOTS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference: walk whole runs, then cut each into pieces of up to four.
  task automatic model(input logic [63:0] h, input int cin);
    int c;
    m_cnt = 0; m_ovf = 0; m_cout = 0; c = 0;
    for (int k = 0; k < SLOTS; k++) begin m_col[k] = 0; m_len[k] = 0; end
    while (c < COLS) begin
      if (h[c]) begin
        int L, cap, pos, left, piece;
        L = 0;
        while (c + L < COLS && h[c+L]) L++;
        cap = (c == 0 && cin != 0) ? 4 - cin : 4;
        pos = c; left = L;
        while (left > 0) begin
          piece = (left < cap) ? left : cap;
          if (m_cnt < SLOTS) begin
            m_col[m_cnt] = pos; m_len[m_cnt] = piece - 1;
            m_cnt++;
          end else m_ovf = 1;
          pos += piece; left -= piece; cap = 4;
        end
        if (c + L == COLS) m_cout = 2'(((c == 0) ? cin + L : L) % 4);
        c += L;
      end else c++;
    end
  endtask

  task automatic check_slots(input string req);
    int cnt;
    cnt = $countones(slot_valid);
    check(cnt == m_cnt, req, "piece count", cnt, m_cnt);
    check(res_overflow == m_ovf, "R3", "overflow", int'(res_overflow), int'(m_ovf));
    for (int k = 0; k < SLOTS; k++) begin
      check(slot_valid[k] == (k < m_cnt), "R2", "slot valid", int'(slot_valid[k]), int'(k < m_cnt));
      if (k < m_cnt) begin
        check(int'(slot_col[k*COL_W +: COL_W]) == m_col[k], req, "slot column",
              int'(slot_col[k*COL_W +: COL_W]), m_col[k]);
        check(int'(slot_len[k*2 +: 2]) == m_len[k], req, "slot size code",
              int'(slot_len[k*2 +: 2]), m_len[k]);
      end
    end
  endtask

  task automatic run_vec(input logic [63:0] h, input logic [1:0] cin, input string req);
    @(negedge clk);
    in_hits = h; in_carry = cin; in_valid = 1'b1; res_ready = 1'b1;
    #1;
    model(h, int'(cin));
    check(out_carry == m_cout, "R5", "carry out", int'(out_carry), int'(m_cout));
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid == 1'b1, "R6", "result valid", int'(res_valid), 1);
    check_slots(req);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R8", "valid in reset", int'(res_valid), 0);
    check(slot_valid == '0, "R8", "slots in reset", int'(slot_valid), 0);
    check(res_overflow == 1'b0, "R8", "overflow in reset", int'(res_overflow), 0);
    rst_n = 1'b1;

    // R1 R4 table walk: summary columns, then full model comparison
    for (int v = 0; v < NV; v++) begin
      run_vec(T_HITS[v], T_CIN[v], (T_CIN[v] != 0) ? "R4" : "R1");
      check($countones(slot_valid) == T_CNT[v], "R3", "table count",
            $countones(slot_valid), T_CNT[v]);
      check(res_overflow == T_OVF[v], "R3", "table overflow",
            int'(res_overflow), int'(T_OVF[v]));
      check(out_carry == T_COUT[v], "R5", "table carry out",
            int'(out_carry), int'(T_COUT[v]));
      if (T_CNT[v] > 0) begin
        check(int'(slot_col[COL_W-1:0]) == T_COL0[v], "R1", "table first column",
              int'(slot_col[COL_W-1:0]), T_COL0[v]);
        check(slot_len[1:0] == T_LEN0[v], "R1", "table first size",
              int'(slot_len[1:0]), int'(T_LEN0[v]));
      end
    end

    // R7: back-pressure holds the result and blocks the next slice
    @(negedge clk);
    in_hits = 64'hF0; in_carry = 0; in_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    in_hits = 64'h8000_0000_0000_0001;
    #1;
    check(in_ready == 1'b0, "R7", "ready while held", int'(in_ready), 0);
    @(negedge clk);
    model(64'hF0, 0);
    check(res_valid == 1'b1, "R7", "valid while held", int'(res_valid), 1);
    check_slots("R7");
    res_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7", "ready on drain", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    model(64'h8000_0000_0000_0001, 0);
    check_slots("R7");
    @(negedge clk);
    check(res_valid == 1'b0, "R7", "drained empty", int'(res_valid), 0);

    // R4: carry ignored when column 0 idle but column 1 hit
    run_vec(64'h1E, 2'd3, "R4");
    check(slot_len[1:0] == 2'd3, "R4", "carry ignored size", int'(slot_len[1:0]), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule